// File: doc/BRIEF.md
# Integer ALU with condition-flag register

This block is the execution-stage arithmetic and logic unit of a register-to-register RISC core. Its two operands come only from the register file. The second operand arrives already shifted by a separate shifter, which also supplies that shifter's carry-out. A 4-bit operation code selects one of sixteen functions:

- **Arithmetic:** add and subtract, each with or without a carry-in. Subtraction also has reversed forms, where the first operand is taken from the second.
- **Bitwise logic:** AND, OR, XOR, bit clear, pass and pass-inverted.
- **Flag-only:** four operations that compute a value purely to set the condition flags.

The result and its write-enable are combinational. The N, Z, C and V condition flags are held in a small register inside the block. That register loads on the clock edge when the set-flags control is high, or whenever a flag-only operation is presented. The carry-in used by the carry forms is an explicit input, so the core decides whether it comes from the held flag or from elsewhere. The block is combinational apart from the flag register, so it has no state sequence. Its only transitions are "flags load" and "flags hold", chosen on each clock.

Top module: `alu_core`

## Requirements
- R1: With opcode 4 the result is a+b. With opcode 5 the result is a+b+carry_in. All arithmetic wraps modulo 2^32.
- R2: The subtract family is opcode 2 (a−b), opcode 3 (b−a), opcode 6 (a−b+carry_in−1) and opcode 7 (b−a+carry_in−1).
- R3: The bitwise family is opcode 0 (a AND b), opcode 1 (a XOR b), opcode 12 (a OR b), opcode 13 (b), opcode 14 (a AND NOT b) and opcode 15 (NOT b).
- R4: result_we is 0 for opcodes 8 to 11 and 1 for every other opcode.
- R5: Opcodes 8 to 11 load the flags on the next clock even when set_flags is 0. They compute a AND b (8), a XOR b (9), a−b (10) and a+b (11).
- R6: On a flag load, N (flags[3]) takes bit 31 of the computed value. Z (flags[2]) is 1 exactly when that value is zero.
- R7: For arithmetic operations, C (flags[1]) is the carry out of the addition. For subtractions this carry is NOT borrow, so a subtraction with no borrow gives C=1.
- R8: For arithmetic operations, V (flags[0]) is 1 exactly when the signed two's-complement result overflows.
- R9: For bitwise operations, a flag load sets C to shift_carry and leaves V at its previous value.
- R10: When set_flags is 0 and the opcode is not 8 to 11, the flags keep their value across the clock.
- R11: While rst_n is low, the flags are 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second operand, already shifted |
| carry_in | input | 1 | Carry used by opcodes 5, 6, 7 |
| shift_carry | input | 1 | Carry-out of the shifter |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Load flags for non-compare operations |
| result | output | 32 | Computed value |
| result_we | output | 1 | Result is to be written back |
| flags | output | 4 | Held N, Z, C, V (bits 3..0) |

## Verification
The bench builds the block at its default 32-bit width. This makes the signed boundaries 0x7FFFFFFF and 0x80000000 meaningful for overflow, and makes the all-ones operand meaningful for the carry chain. Every opcode is swept across those boundary operands with both carry-in values. A long random run then follows, with set_flags and shift_carry toggling, so that the flag-hold and V-preserve paths interleave with loads.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        ALU_AND    = 4'd0,
        ALU_XOR    = 4'd1,
        ALU_SUB    = 4'd2,
        ALU_RSUB   = 4'd3,
        ALU_ADD    = 4'd4,
        ALU_ADDC   = 4'd5,
        ALU_SUBC   = 4'd6,
        ALU_RSUBC  = 4'd7,
        ALU_TAND   = 4'd8,
        ALU_TXOR   = 4'd9,
        ALU_CSUB   = 4'd10,
        ALU_CADD   = 4'd11,
        ALU_OR     = 4'd12,
        ALU_PASS   = 4'd13,
        ALU_CLR    = 4'd14,
        ALU_PASSN  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        LOG_AND  = 2'd0,
        LOG_XOR  = 2'd1,
        LOG_OR   = 2'd2,
        LOG_PASS = 2'd3
    } log_sel_e;

    typedef struct packed {
        logic     arith;
        logic     swap;
        logic     inv_y;
        cin_sel_e cin_sel;
        logic     wr;
        log_sel_e lsel;
        logic     inv_b;
    } alu_ctrl_t;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int NFLAGS = 4;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] opcode,
    output alu_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{arith: 1'b0, swap: 1'b0, inv_y: 1'b0, cin_sel: CIN_ZERO,
                 wr: 1'b1, lsel: LOG_AND, inv_b: 1'b0};
        unique case (alu_op_e'(opcode))
            ALU_AND:   ctrl.lsel = LOG_AND;
            ALU_XOR:   ctrl.lsel = LOG_XOR;
            ALU_SUB:   begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE; end
            ALU_RSUB:  begin ctrl.arith = 1'b1; ctrl.swap = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE; end
            ALU_ADD:   ctrl.arith = 1'b1;
            ALU_ADDC:  begin ctrl.arith = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            ALU_SUBC:  begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            ALU_RSUBC: begin ctrl.arith = 1'b1; ctrl.swap = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            ALU_TAND:  begin ctrl.wr = 1'b0; ctrl.lsel = LOG_AND; end
            ALU_TXOR:  begin ctrl.wr = 1'b0; ctrl.lsel = LOG_XOR; end
            ALU_CSUB:  begin ctrl.wr = 1'b0; ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE; end
            ALU_CADD:  begin ctrl.wr = 1'b0; ctrl.arith = 1'b1; end
            ALU_OR:    ctrl.lsel = LOG_OR;
            ALU_PASS:  ctrl.lsel = LOG_PASS;
            ALU_CLR:   begin ctrl.lsel = LOG_AND; ctrl.inv_b = 1'b1; end
            ALU_PASSN: begin ctrl.lsel = LOG_PASS; ctrl.inv_b = 1'b1; end
            default:   ctrl.lsel = LOG_AND;
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;
    logic [WIDTH:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = full[MSB:0];
        cout = full[WIDTH];
        ovf  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NFLAGS-1:0] next_flags,
    output logic [NFLAGS-1:0] flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (load) begin
            flags_q <= next_flags;
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             shift_carry,
    input  logic [3:0]       opcode,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] add_x, add_y, add_sum, b_eff, log_res;
    logic             add_cin, add_cout, add_ovf, flag_load;
    logic [NFLAGS-1:0] next_flags;

    alu_decode u_dec (.opcode(opcode), .ctrl(ctrl));

    always_comb begin
        add_x = ctrl.swap ? op_b : op_a;
        add_y = ctrl.swap ? op_a : op_b;
        if (ctrl.inv_y) add_y = ~add_y;
        unique case (ctrl.cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = carry_in;
            default:  add_cin = 1'b0;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    always_comb begin
        b_eff = ctrl.inv_b ? ~op_b : op_b;
        unique case (ctrl.lsel)
            LOG_AND:  log_res = op_a & b_eff;
            LOG_XOR:  log_res = op_a ^ b_eff;
            LOG_OR:   log_res = op_a | b_eff;
            default:  log_res = b_eff;
        endcase
    end

    always_comb begin
        result    = ctrl.arith ? add_sum : log_res;
        result_we = ctrl.wr;
        flag_load = set_flags || !ctrl.wr;
        next_flags[FLAG_N] = result[MSB];
        next_flags[FLAG_Z] = (result == '0);
        next_flags[FLAG_C] = ctrl.arith ? add_cout : shift_carry;
        next_flags[FLAG_V] = ctrl.arith ? add_ovf : flags[FLAG_V];
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .load(flag_load),
        .next_flags(next_flags), .flags_q(flags)
    );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_b,
    input logic             shift_carry,
    input logic [3:0]       opcode,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [3:0]       flags
);
    logic is_cmp, is_logic;
    always_comb begin
        is_cmp   = (opcode[3:2] == 2'b10);
        is_logic = !((opcode >= 4'd2 && opcode <= 4'd7) || opcode == 4'd10 || opcode == 4'd11);
    end

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !result_we);

    // R4
    op_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |-> result_we);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && !is_cmp) |=> $stable(flags));

    // R9
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && is_logic && !is_cmp) |=> (flags[1] == $past(shift_carry)) && (flags[0] == $past(flags[0])));

    // R6
    nz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && result_we) |=> (flags[3] == $past(result[WIDTH-1])) && (flags[2] == ($past(result) == '0)));

    // R3
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd13) |-> (result == op_b));
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_b(op_b), .shift_carry(shift_carry),
    .opcode(opcode), .set_flags(set_flags), .result(result),
    .result_we(result_we), .flags(flags)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W = 32;
    localparam longint M = 64'h1_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          carry_in = 1'b0, shift_carry = 1'b0, set_flags = 1'b0;
    logic [3:0]    opcode = 4'd0;
    logic [W-1:0]  result;
    logic          result_we;
    logic [3:0]    flags;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags = 4'b0000;

    always #4 clk = ~clk;

    alu_core #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .shift_carry(shift_carry), .opcode(opcode),
        .set_flags(set_flags), .result(result), .result_we(result_we),
        .flags(flags)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h act=%h exp=%h", tag, opcode, op_a, op_b, act, exp);
        end
    endtask

    function automatic longint sx(input logic [W-1:0] v);
        return v[W-1] ? longint'(v) - M : longint'(v);
    endfunction

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic sc, input logic sf);
        longint ua, ub, us, ss, bi;
        logic [W-1:0] er;
        logic arith, ec, ev, cmp, load;
        logic [3:0] nf;
        string rtag, ftag;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; carry_in = ci; shift_carry = sc; set_flags = sf;
        ua = longint'(a); ub = longint'(b); bi = ci ? 0 : 1;
        arith = 1'b1; ec = 1'b0; ev = 1'b0; er = '0;
        cmp = (op >= 4'd8 && op <= 4'd11);
        rtag = "R1";
        case (op)
            4'd4, 4'd11: begin us = ua + ub; ss = sx(a) + sx(b); ec = us >= M; end
            4'd5: begin us = ua + ub + (ci ? 1 : 0); ss = sx(a) + sx(b) + (ci ? 1 : 0); ec = us >= M; end
            4'd2, 4'd10: begin us = ua - ub; ss = sx(a) - sx(b); ec = us >= 0; rtag = "R2"; end
            4'd3: begin us = ub - ua; ss = sx(b) - sx(a); ec = us >= 0; rtag = "R2"; end
            4'd6: begin us = ua - ub - bi; ss = sx(a) - sx(b) - bi; ec = us >= 0; rtag = "R2"; end
            4'd7: begin us = ub - ua - bi; ss = sx(b) - sx(a) - bi; ec = us >= 0; rtag = "R2"; end
            default: begin arith = 1'b0; rtag = "R3"; end
        endcase
        if (arith) begin
            er = us[W-1:0];
            ev = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end else begin
            case (op)
                4'd0, 4'd8: er = a & b;
                4'd1, 4'd9: er = a ^ b;
                4'd12: er = a | b;
                4'd13: er = b;
                4'd14: er = a & ~b;
                default: er = ~b;
            endcase
            ec = sc; ev = mflags[0];
        end
        load = sf || cmp;
        nf = load ? {er[W-1], er == '0, ec, ev} : mflags;
        #2;
        if (!cmp) chk(rtag, result, er);
        chk("R4", {31'b0, result_we}, {31'b0, !cmp});
        @(posedge clk);
        mflags = nf;
        #2;
        if (!load) ftag = "R10";
        else if (cmp) ftag = "R5";
        else if (!arith) ftag = "R9";
        else ftag = "R7 R8";
        chk(ftag, {28'b0, flags}, {28'b0, nf});
        if (load) chk("R6", {30'b0, flags[3:2]}, {30'b0, nf[3:2]});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] corner [6];
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'h7FFF_FFFF;
        corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h1234_5678;
        repeat (2) @(posedge clk);
        #2;
        chk("R11", {28'b0, flags}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        apply(4'(op), corner[i], corner[j], c[0], ~c[0], (i + j) % 3 != 0);
        for (int k = 0; k < 4000; k++)
            apply(4'($urandom_range(0, 15)), $urandom, $urandom,
                  1'($urandom), 1'($urandom), 1'($urandom));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule